// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Master

This block is a register-driven SPI master that moves exactly one byte per transfer. Software selects a device by setting its chip-select enable bit, picks a clock mode and divider in the configuration word, then writes a byte into the transmit register. That write launches a full-duplex exchange: the byte leaves on the serial data output, most significant bit first, while the byte arriving on the serial data input is collected. While the exchange runs, the ready flag in the control word stays low. When it rises again, the captured byte can be read from the receive register.

The serial clock is derived from the block clock by a five-bit divider code that covers two ranges. Codes below 16 divide directly. Codes with the top bit set divide by twice their low nibble. The codes that would give a divisor below two are forced to divide by two. The configuration word also carries a flush request bit that clears itself after a fixed number of cycles. Two further option bits are stored and read back, but they have no effect: transfers are always one byte.

Registers sit on a simple single-cycle bus. A write happens on the clock edge where select and write-enable are both high. Read data is combinational from the word address.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the control word (address 0x0) reads 0x0000_0002, with the ready flag at bit 1. The configuration word (0x4), transmit word (0x8) and receive word (0xC) all read zero, and every chip-select output is high.
- R2: Control bits 16+n hold the enable for device n. cs_no[n] is low exactly while that bit is set, from the clock edge that writes it, and the bits read back in place.
- R3: A write to 0x8 while ready is high starts a transfer of bits 7:0, most significant bit first on mosi_o. The ready flag reads low for exactly 8×D clock cycles, where D is the divider from R7.
- R4: At the end of a transfer, the eight bits sampled from miso_i (first sample in bit 7) read back from bits 7:0 of 0xC. The value is unchanged until the next transfer completes.
- R5: Configuration bit 7 sets the serial clock level whenever no transfer runs: 0 = low, 1 = high. The first edge of each bit moves away from that level.
- R6: Configuration bit 6 selects the phase. With 0, the output bit is valid before the first edge and input is sampled on the first edge of each bit. With 1, the output bit changes on the first edge and input is sampled on the second edge. All four polarity/phase combinations exchange bytes correctly.
- R7: Configuration bits 4:0 hold the divider code C. For C from 2 to 15, D = C. For C from 0x11 to 0x1F, D = 2×C[3:0]. For C = 0, 1 or 0x10, D = 2. The serial clock period during a transfer is D clock cycles.
- R8: Writing 1 to configuration bit 9 makes it read 1 for FLUSH_CYCLES clock cycles, after which it reads 0 on its own. The other configuration bits are kept.
- R9: Configuration bits 5 and 17 are stored and read back. They change neither the transfer length nor the received data.
- R10: A write to 0x8 while ready is low is dropped. The transmit word keeps the byte of the running transfer, and that transfer's length and data are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable for the selected register |
| bus_addr_i | input | ADDR_W (4) | Byte address; bits 3:2 pick the word |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for bus_addr_i |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | NUM_CS (4) | Chip selects, active low |

## Verification
The bench builds the block with NUM_CS = 4 and FLUSH_CYCLES = 4. Four select lines let a multi-bit enable pattern be written and checked against each output pin. The short flush window means the self-clearing bit can be seen both set and cleared within a handful of bus reads. The five-bit divider width lets the bench reach the largest divisor, 30, where one transfer lasts 240 cycles and the serial clock period is measured directly. A slave model answers each byte with the inverse of the byte it received before, so bit order and sampling phase are both visible in every received value.

// File: rtl/spi_master_pkg.sv
`timescale 1ns/1ps
package spi_master_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_TX   = 2'd2,
    REG_RX   = 2'd3
  } reg_sel_e;

  localparam int PRESC_W        = 5;
  localparam int CTRL_READY_BIT = 1;
  localparam int CTRL_CS_LSB    = 16;
  localparam int CFG_WIDE_BIT   = 5;
  localparam int CFG_PHASE_BIT  = 6;
  localparam int CFG_POL_BIT    = 7;
  localparam int CFG_FLUSH_BIT  = 9;
  localparam int CFG_QUEUE_BIT  = 17;
endpackage

// File: rtl/spi_presc_map.sv
`timescale 1ns/1ps
module spi_presc_map #(
  parameter int CODE_W = 5,
  localparam int DW = CODE_W + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [DW-1:0]     div_o
);
  logic [CODE_W-2:0] lo;
  assign lo = code_i[CODE_W-2:0];

  always_comb begin
    if (code_i[CODE_W-1]) div_o = (lo == '0) ? DW'(2) : DW'({lo, 1'b0});
    else                  div_o = (code_i < CODE_W'(2)) ? DW'(2) : DW'(code_i);
  end

  always_comb begin
    AST_DIV_FLOOR: assert (div_o >= DW'(2)) else $error("divider below two"); // R7
  end
endmodule

// File: rtl/spi_flush_timer.sv
`timescale 1ns/1ps
module spi_flush_timer #(
  parameter int HOLD = 4,
  localparam int CW = $clog2(HOLD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic pend_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      cnt_q  <= '0;
    end else if (set_i) begin
      pend_o <= 1'b1;
      cnt_q  <= CW'(HOLD - 1);
    end else if (pend_o) begin
      if (cnt_q == '0) pend_o <= 1'b0;
      else             cnt_q  <= cnt_q - CW'(1);
    end
  end

  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && cnt_q == '0 && !set_i) |=> !pend_o) else $error("flush stuck"); // R8
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       tx_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic [7:0]       rx_o
);
  logic             busy_q, act_q, mosi_q, cpol_q, cpha_q;
  logic [DIV_W-1:0] cnt_q, div_q, half_w;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q, rx_q, rx_out_q;
  logic             lead_hit, trail_hit;

  assign half_w    = div_q >> 1;
  assign lead_hit  = busy_q && (cnt_q == half_w - DIV_W'(1));
  assign trail_hit = busy_q && (cnt_q == div_q - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; act_q <= 1'b0; mosi_q <= 1'b0;
      cpol_q <= 1'b0; cpha_q <= 1'b0;
      cnt_q <= '0; div_q <= DIV_W'(2); bit_q <= '0;
      tx_q <= '0; rx_q <= '0; rx_out_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      div_q  <= div_i;
      cpol_q <= cpol_i;
      cpha_q <= cpha_i;
      rx_q   <= '0;
      if (cpha_i) tx_q <= tx_i;
      else begin
        mosi_q <= tx_i[7];
        tx_q   <= {tx_i[6:0], 1'b0};
      end
    end else if (busy_q) begin
      cnt_q <= trail_hit ? '0 : cnt_q + DIV_W'(1);
      if (lead_hit) begin
        act_q <= 1'b1;
        if (cpha_q) begin
          mosi_q <= tx_q[7];
          tx_q   <= {tx_q[6:0], 1'b0};
        end else rx_q <= {rx_q[6:0], miso_i};
      end
      if (trail_hit) begin
        act_q <= 1'b0;
        bit_q <= bit_q + 3'd1;
        if (cpha_q) rx_q <= {rx_q[6:0], miso_i};
        else begin
          mosi_q <= tx_q[7];
          tx_q   <= {tx_q[6:0], 1'b0};
        end
        if (bit_q == 3'd7) begin
          busy_q   <= 1'b0;
          rx_out_q <= cpha_q ? {rx_q[6:0], miso_i} : rx_q;
        end
      end
    end
  end

  // idle level follows live config; during a transfer the latched mode rules
  assign sck_o  = busy_q ? (act_q ^ cpol_q) : cpol_i;
  assign mosi_o = mosi_q;
  assign busy_o = busy_q;
  assign rx_o   = rx_out_q;

  AST_START_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && !act_q)) else $error("start not taken"); // R3
  AST_IDLE_NO_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !act_q) else $error("clock active while idle"); // R5
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
  import spi_master_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 32,
  parameter int NUM_CS       = 4,
  parameter int FLUSH_CYCLES = 4,
  localparam int DIV_W = PRESC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no
);
  reg_sel_e           reg_e;
  logic               wr, wr_ctrl, wr_cfg, wr_tx, start, ready, busy, flush_pend;
  logic [NUM_CS-1:0]  cs_q;
  logic [PRESC_W-1:0] presc_q;
  logic               wide_q, phase_q, pol_q, queue_q;
  logic [7:0]         tx_q, rx_w;
  logic [DIV_W-1:0]   div_w;
  logic               unused_bits;

  assign reg_e   = reg_sel_e'(bus_addr_i[3:2]);
  assign wr      = bus_sel_i && bus_we_i;
  assign wr_ctrl = wr && (reg_e == REG_CTRL);
  assign wr_cfg  = wr && (reg_e == REG_CFG);
  assign wr_tx   = wr && (reg_e == REG_TX);
  assign ready   = !busy;
  assign start   = wr_tx && ready;
  assign unused_bits = ^{bus_wdata_i, bus_addr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= '0; presc_q <= '0; wide_q <= 1'b0; phase_q <= 1'b0;
      pol_q <= 1'b0; queue_q <= 1'b0; tx_q <= '0;
    end else begin
      if (wr_ctrl) cs_q <= bus_wdata_i[CTRL_CS_LSB +: NUM_CS];
      if (wr_cfg) begin
        presc_q <= bus_wdata_i[PRESC_W-1:0];
        wide_q  <= bus_wdata_i[CFG_WIDE_BIT];
        phase_q <= bus_wdata_i[CFG_PHASE_BIT];
        pol_q   <= bus_wdata_i[CFG_POL_BIT];
        queue_q <= bus_wdata_i[CFG_QUEUE_BIT];
      end
      if (start) tx_q <= bus_wdata_i[7:0];
    end
  end

  assign cs_no = ~cs_q;

  spi_presc_map #(.CODE_W(PRESC_W)) u_presc (
    .code_i (presc_q),
    .div_o  (div_w)
  );

  spi_flush_timer #(.HOLD(FLUSH_CYCLES)) u_flush (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr_cfg && bus_wdata_i[CFG_FLUSH_BIT]),
    .pend_o (flush_pend)
  );

  spi_shift_engine #(.DIV_W(DIV_W)) u_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .tx_i   (bus_wdata_i[7:0]),
    .div_i  (div_w),
    .cpol_i (pol_q),
    .cpha_i (phase_q),
    .miso_i (miso_i),
    .busy_o (busy),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .rx_o   (rx_w)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (reg_e)
      REG_CTRL: begin
        bus_rdata_o[CTRL_READY_BIT]            = ready;
        bus_rdata_o[CTRL_CS_LSB +: NUM_CS]     = cs_q;
      end
      REG_CFG: begin
        bus_rdata_o[PRESC_W-1:0]   = presc_q;
        bus_rdata_o[CFG_WIDE_BIT]  = wide_q;
        bus_rdata_o[CFG_PHASE_BIT] = phase_q;
        bus_rdata_o[CFG_POL_BIT]   = pol_q;
        bus_rdata_o[CFG_FLUSH_BIT] = flush_pend;
        bus_rdata_o[CFG_QUEUE_BIT] = queue_q;
      end
      REG_TX:  bus_rdata_o[7:0] = tx_q;
      REG_RX:  bus_rdata_o[7:0] = rx_w;
      default: bus_rdata_o = '0;
    endcase
  end

  AST_CS_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (cs_no == ~$past(bus_wdata_i[CTRL_CS_LSB +: NUM_CS]))) else $error("cs mismatch"); // R2
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tx && busy) |=> $stable(tx_q)) else $error("busy write taken"); // R10
endmodule

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, mosi, miso;
  logic [3:0]  cs_n;

  int tests = 0, fails = 0, cyc = 0, wr_t = 0, mon_err = 0;
  bit done = 1'b0;
  logic [3:0] cs_m = '0;
  bit cpol_m = 1'b0, cpha_m = 1'b0;
  logic [7:0] s_tx = '0, s_rx = '0, s_last = 8'h6C;
  int lead_n = 0, lead1 = 0, lead2 = 0;
  logic sck_prev = 1'b0;

  assign miso = s_tx[7];

  spi_byte_master #(.NUM_CS(4), .FLUSH_CYCLES(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // per-clock reference compare: chip selects and idle clock level
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (cs_n !== ~cs_m) mon_err++;
      if (cs_n === 4'hF && sck !== cpol_m) mon_err++;
    end
  end

  // behavioural slave: answers with the inverse of its last received byte
  always @(negedge clk) begin
    if (!cs_n[0] && sck !== sck_prev) begin
      if (sck !== cpol_m) begin
        lead_n++;
        if (lead_n == 1) lead1 = cyc;
        if (lead_n == 2) lead2 = cyc;
        if (!cpha_m) s_rx = {s_rx[6:0], mosi};
        else if (lead_n > 1) s_tx = {s_tx[6:0], 1'b0};
      end else begin
        if (!cpha_m) s_tx = {s_tx[6:0], 1'b0};
        else s_rx = {s_rx[6:0], mosi};
      end
    end
    sck_prev = sck;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr_t = cyc;
    if (a == 4'h0) cs_m = d[19:16];
    if (a == 4'h4) begin cpol_m = d[7]; cpha_m = d[6]; end
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 v = rdata;
  endtask

  task automatic set_cfg(input logic [31:0] c, input string tag);
    bus_write(4'h0, 32'h0);
    bus_write(4'h4, c);
    chk(sck === c[7], tag, {31'h0, sck}, {31'h0, c[7]});
    bus_write(4'h0, 32'h0001_0000);
  endtask

  task automatic xfer(input logic [7:0] tx, input int d, input bit spoil, input string tag);
    logic [31:0] v;
    logic [7:0]  exp_rx;
    int t0;
    exp_rx = ~s_last;
    s_tx = exp_rx; s_rx = '0; lead_n = 0;
    bus_write(4'h8, {24'h0, tx});
    t0 = wr_t;
    if (spoil) bus_write(4'h8, 32'hFF);
    do bus_read(4'h0, v); while (!v[1]);
    chk(cyc - t0 == 8 * d, {tag, " R3 ready-low cycles"}, cyc - t0, 8 * d);
    chk(lead2 - lead1 == d, {tag, " R7 sck period"}, lead2 - lead1, d);
    chk(s_rx === tx, {tag, " R3 byte seen by slave"}, {24'h0, s_rx}, {24'h0, tx});
    bus_read(4'hC, v);
    chk(v === {24'h0, exp_rx}, {tag, " R4 R6 received byte"}, v, {24'h0, exp_rx});
    if (spoil) begin
      bus_read(4'h8, v);
      chk(v === {24'h0, tx}, {tag, " R10 transmit word kept"}, v, {24'h0, tx});
    end
    s_last = s_rx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int codes [8] = '{0, 1, 3, 5, 15, 16, 19, 31};
    int divs  [8] = '{2, 2, 3, 5, 15, 2, 6, 30};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(4'h0, v); chk(v === 32'h2, "R1 control reset", v, 32'h2);
    bus_read(4'h4, v); chk(v === 32'h0, "R1 config reset", v, 32'h0);
    bus_read(4'h8, v); chk(v === 32'h0, "R1 transmit reset", v, 32'h0);
    bus_read(4'hC, v); chk(v === 32'h0, "R1 receive reset", v, 32'h0);
    chk(cs_n === 4'hF, "R1 R2 selects idle", {28'h0, cs_n}, 32'hF);

    // R2 select pattern and readback
    bus_write(4'h0, 32'h000A_0000);
    chk(cs_n === 4'b0101, "R2 select pins", {28'h0, cs_n}, 32'h5);
    bus_read(4'h0, v); chk(v === 32'h000A_0002, "R2 select readback", v, 32'h000A_0002);

    // R5 R6 all four modes
    for (int m = 0; m < 4; m++) begin
      set_cfg(32'h2 | (32'(m & 2) << 6) | (32'(m & 1) << 6), "R5 idle level");
      xfer(8'h96 ^ 8'(m * 37), 2, 1'b0, "R6 mode");
    end

    // R7 divider codes
    for (int i = 0; i < 8; i++) begin
      set_cfg(32'(codes[i]), "R5 idle level");
      xfer(8'h1E + 8'(i * 29), divs[i], 1'b0, "R7 divider");
    end

    // R9 stored option bits
    set_cfg(32'h0002_0022, "R5 idle level");
    bus_read(4'h4, v); chk(v === 32'h0002_0022, "R9 option readback", v, 32'h0002_0022);
    xfer(8'hC7, 2, 1'b0, "R9 options inert");

    // R8 flush self clear
    bus_write(4'h4, 32'h202);
    bus_read(4'h4, v); chk(v[9] === 1'b1, "R8 flush set", v, 32'h202);
    repeat (6) @(negedge clk);
    bus_read(4'h4, v); chk(v === 32'h2, "R8 flush cleared", v, 32'h2);

    // R10 write while busy
    set_cfg(32'h43, "R5 idle level");
    xfer(8'h3C, 3, 1'b1, "R10 busy write");

    bus_write(4'h0, 32'h0);
    chk(cs_n === 4'hF, "R2 deselect", {28'h0, cs_n}, 32'hF);
    repeat (3) @(negedge clk);
    chk(mon_err == 0, "R2 R5 per-clock monitor", mon_err, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule